// File: doc/BRIEF.md
# Shopping Cart Price Accumulator

This block keeps the running purchase total of a shopping cart. A small writable table, addressed by a 4-bit item code, stores one 14-bit amount per entry. Each entry also has a kind bit that marks the amount as either a shelf price or a coupon. Software or a host controller first loads the table through an update operation. After that, every scanned item is either added to the cart or taken out of it. The block looks the item up and shows its amount on a last-price output one cycle before the total absorbs it. It then raises a one-cycle done strobe.

All operands arrive on one shared data bus. A 2-bit operation code picks the action that starts in a given cycle. An update uses two consecutive cycles on the bus, and an add or remove uses one. A single 14-bit add/subtract unit does all the arithmetic. Carry-in 0 gives A+B, and carry-in 1 gives A+~B+1. The result saturates at both ends of the range. The unit's operands are forced to zero whenever no accumulate step is running.

Top module: `cart_accum_top`

## Requirements
- R1: A synchronous active-high reset clears `total`, `last_price` and `done` to zero. Table contents are not reset.
- R2: Update (op=2'b01) takes two cycles. In the first cycle `bus_in[3:0]` carries the item code and `bus_in[4]` carries the kind (1 = coupon, 0 = price). In the following cycle `bus_in[13:0]` carries the amount, which is written at the end of that cycle. The op code presented in that second cycle is ignored.
- R3: Add (op=2'b10) takes the item code on `bus_in[3:0]`. The entry amount appears on `last_price` after the second rising edge, counting the accepting edge as the first. `total` includes it after the third edge.
- R4: Remove (op=2'b11) uses the same timing as add and subtracts the entry amount from `total`.
- R5: For a coupon entry, the direction is reversed: add subtracts the coupon amount, and remove adds it back.
- R6: A subtraction whose result would be negative leaves `total` at 0.
- R7: An addition whose result would exceed 16383 leaves `total` at 16383.
- R8: `done` is high for exactly one cycle, and that is the cycle in which the updated `total` first appears. It is low at all other times.
- R9: While an add or remove is in progress (the two cycles after it is accepted), the op code is ignored. The next operation can be accepted in the cycle in which `done` is high.
- R10: With op=2'b00 (idle), `total` and `last_price` keep their values whatever `bus_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | Operation code: 00 idle, 01 update, 10 add, 11 remove |
| bus_in | input | 14 | Shared operand bus: code/kind, or amount |
| last_price | output | 14 | Amount of the most recently looked-up entry |
| total | output | 14 | Running cart total |
| done | output | 1 | One-cycle strobe when the total has been updated |

## Verification
The hardest cases to reach are the two saturation clamps and the coupon-reversed direction. Each needs a particular running total combined with a particular table entry. The bench makes the state known first. It reloads entries with chosen amounts and kinds, and it uses reset to bring the total to zero while the table keeps its contents. It then sweeps every code through add and remove, applies an oversized price twice to drive past the top of the range, and removes a large item from a small total. During busy cycles and during the update-value cycle it places live add and remove codes on the op pins, so that any operation wrongly accepted there would show up as a shifted or extra total change.

// File: rtl/cart_pkg.sv
package cart_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_UPDATE = 2'b01,
        OP_ADD    = 2'b10,
        OP_REMOVE = 2'b11
    } cart_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WVAL = 2'b01,
        ST_LOOK = 2'b10,
        ST_ACC  = 2'b11
    } cart_st_e;

    localparam int unsigned AMT_W_DEF  = 14;
    localparam int unsigned CODE_W_DEF = 4;
    localparam int unsigned BLK_W_DEF  = 7;

endpackage

// File: rtl/cart_table.sv
module cart_table #(
    parameter int unsigned AMT_W  = 14,
    parameter int unsigned CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CODE_W-1:0] waddr,
    input  logic [AMT_W-1:0]  wamt,
    input  logic              wcoupon,
    input  logic [CODE_W-1:0] raddr,
    output logic [AMT_W-1:0]  ramt,
    output logic              rcoupon
);
    localparam int unsigned DEPTH = 1 << CODE_W;
    localparam int unsigned ENT_W = AMT_W + 1;

    logic [DEPTH-1:0][ENT_W-1:0] mem_q;
    logic [DEPTH-1:0][ENT_W-1:0] mem_d;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = {wcoupon, wamt};
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign ramt    = mem_q[raddr][AMT_W-1:0];
    assign rcoupon = mem_q[raddr][AMT_W];

    // R2: the table only changes in a write cycle
    p_table_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem_q));

endmodule

// File: rtl/cart_addsub.sv
module cart_addsub #(
    parameter int unsigned AMT_W = 14,
    parameter int unsigned BLK_W = 7
) (
    input  logic             en,
    input  logic             sub,
    input  logic [AMT_W-1:0] a,
    input  logic [AMT_W-1:0] b,
    output logic [AMT_W-1:0] result,
    output logic             cout
);
    localparam int unsigned NBLK = AMT_W / BLK_W;

    logic [AMT_W-1:0] a_g;
    logic [AMT_W-1:0] b_g;
    logic             cin_g;
    logic [AMT_W-1:0] sum_raw;
    logic             carry [NBLK+1];

    // operand isolation: the adder sees zeros unless a step is running
    assign a_g   = en ? a : '0;
    assign b_g   = en ? (sub ? ~b : b) : '0;
    assign cin_g = en & sub;
    assign carry[0] = cin_g;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic [BLK_W:0] s0;
        logic [BLK_W:0] s1;
        assign s0 = {1'b0, a_g[g*BLK_W +: BLK_W]} + {1'b0, b_g[g*BLK_W +: BLK_W]};
        assign s1 = {1'b0, a_g[g*BLK_W +: BLK_W]} + {1'b0, b_g[g*BLK_W +: BLK_W]}
                    + {{BLK_W{1'b0}}, 1'b1};
        assign sum_raw[g*BLK_W +: BLK_W] = carry[g] ? s1[BLK_W-1:0] : s0[BLK_W-1:0];
        assign carry[g+1] = carry[g] ? s1[BLK_W] : s0[BLK_W];
    end

    assign cout = carry[NBLK];

    always_comb begin
        if (!en) begin
            result = '0;
        end else if (sub && !cout) begin
            result = '0;            // borrow: clamp low
        end else if (!sub && cout) begin
            result = '1;            // overflow: clamp high
        end else begin
            result = sum_raw;
        end
    end

    // R3: an unclamped addition never yields less than its first operand
    always_comb begin
        if (en && !sub && !cout) begin
            p_add_monotone_r3: assert (result >= a);
        end
    end

endmodule

// File: rtl/cart_accum_top.sv
module cart_accum_top
    import cart_pkg::*;
#(
    parameter int unsigned AMT_W  = AMT_W_DEF,
    parameter int unsigned CODE_W = CODE_W_DEF,
    parameter int unsigned BLK_W  = BLK_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op,
    input  logic [AMT_W-1:0] bus_in,
    output logic [AMT_W-1:0] last_price,
    output logic [AMT_W-1:0] total,
    output logic             done
);
    typedef struct packed {
        cart_st_e          st;
        logic [CODE_W-1:0] code;
        logic              coupon;
        logic              sub;
        logic [AMT_W-1:0]  last;
        logic [AMT_W-1:0]  sum;
        logic              done;
    } regs_t;

    regs_t r_q;
    regs_t r_d;

    logic              tbl_we;
    logic [AMT_W-1:0]  tbl_amt;
    logic              tbl_coupon;
    logic              as_en;
    logic [AMT_W-1:0]  as_res;
    logic              as_cout;
    cart_op_e          op_e;

    assign op_e = cart_op_e'(op);

    cart_table #(.AMT_W(AMT_W), .CODE_W(CODE_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .we      (tbl_we),
        .waddr   (r_q.code),
        .wamt    (bus_in),
        .wcoupon (r_q.coupon),
        .raddr   (r_q.code),
        .ramt    (tbl_amt),
        .rcoupon (tbl_coupon)
    );

    cart_addsub #(.AMT_W(AMT_W), .BLK_W(BLK_W)) u_addsub (
        .en     (as_en),
        .sub    (r_q.sub),
        .a      (r_q.sum),
        .b      (r_q.last),
        .result (as_res),
        .cout   (as_cout)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tbl_we   = 1'b0;
        as_en    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                unique case (op_e)
                    OP_UPDATE: begin
                        r_d.code   = bus_in[CODE_W-1:0];
                        r_d.coupon = bus_in[CODE_W];
                        r_d.st     = ST_WVAL;
                    end
                    OP_ADD, OP_REMOVE: begin
                        r_d.code = bus_in[CODE_W-1:0];
                        r_d.sub  = (op_e == OP_REMOVE);
                        r_d.st   = ST_LOOK;
                    end
                    default: ;
                endcase
            end
            ST_WVAL: begin
                tbl_we = 1'b1;
                r_d.st = ST_IDLE;
            end
            ST_LOOK: begin
                r_d.last = tbl_amt;
                r_d.sub  = r_q.sub ^ tbl_coupon;
                r_d.st   = ST_ACC;
            end
            ST_ACC: begin
                as_en    = 1'b1;
                r_d.sum  = as_res;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st     <= ST_IDLE;
            r_q.code   <= '0;
            r_q.coupon <= 1'b0;
            r_q.sub    <= 1'b0;
            r_q.last   <= '0;
            r_q.sum    <= '0;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign last_price = r_q.last;
    assign total      = r_q.sum;
    assign done       = r_q.done;

    // R8: done never lasts two cycles
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: once a lookup starts, the accumulate step follows regardless of op
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_LOOK) |=> (r_q.st == ST_ACC));

    // R10: total moves only on the cycle that raises done
    p_total_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(total) |-> done);

    // R6: a subtraction larger than the total clamps to zero
    p_sat_low_r6: assert property (@(posedge clk) disable iff (rst)
        (done && $past(r_q.sub) && ($past(last_price) > $past(total)))
        |-> (total == '0));

    // R7: an addition past the range clamps to the maximum
    p_sat_high_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(r_q.sub)
         && ({1'b0, $past(last_price)} + {1'b0, $past(total)} > {1'b0, {AMT_W{1'b1}}}))
        |-> (total == {AMT_W{1'b1}}));

endmodule

// File: tb/sim_cart_accum_top.sv
`timescale 1ns/1ps
module sim_cart_accum_top;

    localparam int MAXV = 16383;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  op;
    logic [13:0] bus_in;
    logic [13:0] last_price;
    logic [13:0] total;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int exp_amt [16];
    bit exp_cpn [16];
    int exp_total;
    int exp_last;

    always #2 clk = ~clk;

    cart_accum_top u0 (
        .clk(clk), .rst(rst), .op(op), .bus_in(bus_in),
        .last_price(last_price), .total(total), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_reset();
        rst = 1'b1; op = 2'b00; bus_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_total = 0; exp_last = 0;
    endtask

    task automatic do_update(input int code, input bit cpn, input int amt, input logic [1:0] filler);
        op = 2'b01; bus_in = 14'((int'(cpn) << 4) | code);
        @(negedge clk);
        op = filler; bus_in = 14'(amt);           // R2: op here is ignored
        @(negedge clk);
        op = 2'b00; bus_in = 14'h3fff;
        exp_amt[code] = amt; exp_cpn[code] = cpn;
        chk("R2 no done after update", int'(done), 0);
    endtask

    task automatic do_item(input int code, input bit rem, input logic [1:0] filler, input string tag);
        int nxt;
        bit sub;
        op = rem ? 2'b11 : 2'b10; bus_in = 14'(code);
        @(negedge clk);
        op = filler; bus_in = 14'(15 - code);     // R9: busy, ignored
        @(negedge clk);
        exp_last = exp_amt[code];
        chk({tag, " last_price"}, int'(last_price), exp_last);
        chk({tag, " total held before step R3"}, int'(total), exp_total);
        chk("R8 done low before step", int'(done), 0);
        op = 2'b01; bus_in = 14'h001f;            // R9: still busy
        @(negedge clk);
        sub = rem ^ exp_cpn[code];
        nxt = sub ? exp_total - exp_amt[code] : exp_total + exp_amt[code];
        if (nxt < 0) nxt = 0;
        if (nxt > MAXV) nxt = MAXV;
        exp_total = nxt;
        chk({tag, " total"}, int'(total), exp_total);
        chk("R8 done high with total", int'(done), 1);
        op = 2'b00;
    endtask

    initial begin : main
        do_reset();
        chk("R1 total after reset", int'(total), 0);
        chk("R1 last_price after reset", int'(last_price), 0);
        chk("R1 done after reset", int'(done), 0);

        for (int i = 0; i < 16; i++) begin
            bit c;
            c = (i % 4 == 3);
            do_update(i, c, c ? (i * 37) % 200 + 5 : (i * 977 + 123) % 1200 + 1,
                      (i % 2 == 0) ? 2'b10 : 2'b11);
        end

        // sweep: add every entry, prices (R3) and coupons (R5)
        for (int i = 0; i < 16; i++)
            do_item(i, 1'b0, 2'(i % 4), (i % 4 == 3) ? "R5 coupon add" : "R3 add");

        // R10: idle with busy bus
        for (int k = 0; k < 6; k++) begin
            bus_in = 14'(k * 2731); op = 2'b00;
            @(negedge clk);
            chk("R10 idle total", int'(total), exp_total);
            chk("R10 idle last_price", int'(last_price), exp_last);
            chk("R8 done low when idle", int'(done), 0);
        end

        // remove every entry in reverse (R4, coupons R5)
        for (int i = 15; i >= 0; i--)
            do_item(i, 1'b1, 2'b10, (i % 4 == 3) ? "R5 coupon remove" : "R4 remove");

        // R1: reset clears total, table retained
        do_reset();
        chk("R1 total after second reset", int'(total), 0);
        do_item(2, 1'b0, 2'b11, "R1 table kept over reset");

        // R6: remove a large item from a small total
        do_update(0, 1'b0, 5000, 2'b10);
        do_item(0, 1'b1, 2'b00, "R6 clamp low");
        chk("R6 total is zero", int'(total), 0);
        do_item(3, 1'b0, 2'b00, "R6 coupon on empty cart");
        chk("R6 coupon leaves zero", int'(total), 0);

        // R7: two oversized prices
        do_update(1, 1'b0, 16000, 2'b11);
        do_item(1, 1'b0, 2'b10, "R7 add big");
        do_item(1, 1'b0, 2'b10, "R7 clamp high");
        chk("R7 total at max", int'(total), MAXV);
        do_item(7, 1'b1, 2'b10, "R7 coupon remove at max");
        chk("R7 still at max", int'(total), MAXV);
        do_item(1, 1'b1, 2'b00, "R4 remove from max");

        // back-to-back: new op accepted in done cycle (R9)
        op = 2'b10; bus_in = 14'd5;
        @(negedge clk); op = 2'b00; @(negedge clk); @(negedge clk);
        exp_total = exp_total + exp_amt[5];
        if (exp_total > MAXV) exp_total = MAXV;
        chk("R9 accepted op result", int'(total), exp_total);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule